// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the time base for one PWM channel. A 16-bit counter advances on a tick that a two-stage prescaler derives from the system clock. The counter can count up, count down, or count up and down in a triangle, always bounded by a period input. It can also be frozen. A sync pulse can force a phase value into the counter and, in the triangle mode, choose the direction of the count that follows. A debug halt request can stop the counter on the next step or at the end of the current cycle, or it can be ignored.

The configuration sits in a 16-bit control register inside the block. A two-bit lane write enable updates it. The low lane holds the count mode, the phase-load enable, the phase direction and the halt behaviour. The high lane holds the two prescale codes, and writing it also restarts the prescaler. Period and phase are plain inputs that take effect at the next clock edge.

Low lane layout: bits [1:0] count mode (0 up, 1 down, 2 up-down, 3 frozen), bit 2 phase-load enable, bit 3 phase direction (1 up, 0 down), bits [5:4] halt behaviour. High lane layout: bits [10:8] first-stage prescale code, bits [13:11] second-stage prescale code. All other bits are ignored.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter output is 0 and the count mode is frozen, so the counter stays at 0 until the mode is changed.
- R2: The tick interval is the product of the two stage divisors. The first stage divides by 1 for code 0 and by twice the code for codes 1 to 7 (2, 4, ... 14).
- R3: The second-stage code n, from 0 to 7, divides by 2 to the power n (1 to 128).
- R4: After reset the first-stage code is 1 (/2) and the second-stage code is 0 (/1), so the tick comes every 2 clocks when only the low lane has been written.
- R5: In up mode (0) each tick adds one, and a value at or above the period goes to 0 on the next tick.
- R6: In down mode (1) each tick subtracts one, and a value of 0 reloads the period on the next tick.
- R7: In up-down mode (2) the counter reverses at the period (the next value is period-1) and reverses at 0 (the next value is 1).
- R8: A sync pulse with phase loading enabled loads the phase value at the next edge, whatever the tick. With phase loading disabled the sync pulse has no effect.
- R9: In up-down mode a phase load sets the following direction from the phase direction bit: 1 counts up, 0 counts down.
- R10: In up and down modes the phase direction bit has no effect on the count after a phase load.
- R11: With halt behaviour 0, the counter takes exactly one more step after the halt request rises, then holds. After the request is released, it resumes on the next tick.
- R12: With halt behaviour 1, a held halt request lets the counter run until it reaches the period (up mode) or 0 (down and up-down modes), and it holds there.
- R13: With halt behaviour 2 or 3, the halt request is ignored and counting continues.
- R14: In frozen mode (3) the counter holds its value while ticks occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Control data written into the control register |
| ctrl_we | input | 2 | Lane write enables: bit 0 low byte, bit 1 high byte |
| period | input | 16 | Period value bounding the count |
| phase | input | 16 | Value loaded on a sync event |
| sync_in | input | 1 | Sync pulse requesting a phase load |
| halt_req | input | 1 | Debug halt request |
| count | output | 16 | Present counter value |
| count_up | output | 1 | Present count direction (1 up) |

## Verification
On every cycle the assertions check that the prescaler's stage counters stay within their limits. They check the wrap at the period in up mode, the reload at 0 in down mode, and the reversal at the period in up-down mode. They also check the phase load and its direction, that the frozen and halted states hold the value, and that counting stays free when halt is ignored. The bench's scenarios are needed to show the actual divide ratios for every prescale code and the reset defaults. Only the bench can show the one-extra-step behaviour when a halt rises between slow ticks, resumption after release, and that a sync without phase enable or a direction bit in a one-way mode leaves the count sequence unchanged.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

   typedef enum logic [1:0] {
      CM_UP   = 2'd0,
      CM_DOWN = 2'd1,
      CM_UPDN = 2'd2,
      CM_HOLD = 2'd3
   } cnt_mode_e;

   typedef enum logic [1:0] {
      EM_STEP  = 2'd0,
      EM_CYCLE = 2'd1,
      EM_FREE0 = 2'd2,
      EM_FREE1 = 2'd3
   } emu_mode_e;

   // low lane of the control register, LSB first: mode, ph_en, ph_dir, emu
   typedef struct packed {
      emu_mode_e emu;
      logic      ph_dir;
      logic      ph_en;
      cnt_mode_e mode;
   } ctrl_lo_t;

   localparam int CTRL_W    = 16;
   localparam int LO_W      = $bits(ctrl_lo_t);
   localparam int PS_CODE_W = 3;
   localparam int HS_LSB    = 8;
   localparam int CD_LSB    = HS_LSB + PS_CODE_W;

   localparam ctrl_lo_t LO_RESET = '{emu: EM_STEP, ph_dir: 1'b0,
                                     ph_en: 1'b0, mode: CM_HOLD};
   localparam logic [PS_CODE_W-1:0] HS_RESET = 3'd1;
   localparam logic [PS_CODE_W-1:0] CD_RESET = 3'd0;

endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
   parameter int HS_BITS = 3,
   parameter int CD_BITS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [HS_BITS-1:0] hs_code,
   input  logic [CD_BITS-1:0] cd_code,
   output logic               tick
);
   localparam int HS_MAX = 2 * ((1 << HS_BITS) - 1);
   localparam int HS_CW  = $clog2(HS_MAX + 1);
   localparam int CD_CW  = (1 << CD_BITS) - 1;

   if (HS_BITS < 1 || HS_BITS > 4) begin : g_bad_hs
      $error("tbase_prescale: HS_BITS out of range");
   end
   if (CD_BITS < 1 || CD_BITS > 4) begin : g_bad_cd
      $error("tbase_prescale: CD_BITS out of range");
   end

   logic [HS_CW-1:0] hs_cnt, hs_lim;
   logic [CD_CW-1:0] cd_cnt, cd_lim;
   logic [CD_CW:0]   cd_full;
   logic             hs_hit, cd_hit;

   always_comb begin
      if (hs_code == '0) hs_lim = '0;
      else               hs_lim = HS_CW'({hs_code, 1'b0}) - HS_CW'(1);
      cd_full = (CD_CW + 1)'(1) << cd_code;
      cd_lim  = cd_full[CD_CW-1:0] - CD_CW'(1);
   end

   assign hs_hit = (hs_cnt >= hs_lim);
   assign cd_hit = (cd_cnt >= cd_lim);
   assign tick   = hs_hit && cd_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_cnt <= '0;
         cd_cnt <= '0;
      end else if (clr) begin
         hs_cnt <= '0;
         cd_cnt <= '0;
      end else if (hs_hit) begin
         hs_cnt <= '0;
         if (cd_hit) cd_cnt <= '0;
         else        cd_cnt <= cd_cnt + CD_CW'(1);
      end else begin
         hs_cnt <= hs_cnt + HS_CW'(1);
      end
   end

   assert_hs_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hs_cnt <= hs_lim);
   assert_cd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cd_cnt <= cd_lim);
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !clr && (hs_lim != '0 || cd_lim != '0) |=> !tick);

endmodule

// File: rtl/tbase_halt.sv
module tbase_halt
   import tbase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             halt_req,
   input  logic             load,
   input  emu_mode_e        emu,
   input  cnt_mode_e        mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] period,
   output logic             step
);
   logic done;
   logic at_end;
   logic may_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    done <= 1'b0;
      else if (!halt_req)                            done <= 1'b0;
      else if (emu == EM_STEP && tick && !load)      done <= 1'b1;
   end

   always_comb begin
      if (mode == CM_UP) at_end = (cnt == period);
      else               at_end = (cnt == '0);
      unique case (emu)
         EM_STEP:  may_step = !(halt_req && done);
         EM_CYCLE: may_step = !(halt_req && at_end);
         default:  may_step = 1'b1;
      endcase
   end

   assign step = tick && may_step;

   assert_step_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      emu == EM_STEP && halt_req && done && !load |=> $stable(cnt));
   assert_cycle_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
      emu == EM_CYCLE && halt_req && !load &&
      ((mode == CM_UP && cnt == period) || (mode != CM_UP && cnt == '0))
      |=> $stable(cnt));
   assert_free_run_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (emu == EM_FREE0 || emu == EM_FREE1) && tick && !load &&
      mode == CM_UP && cnt < period |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/tbase_count.sv
module tbase_count
   import tbase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] phase,
   input  logic             ph_dir,
   input  cnt_mode_e        mode,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_up
);
   logic [CNT_W-1:0] cnt_nx;
   logic             dir_nx;
   logic [CNT_W-1:0] cnt_inc, cnt_dec, first_up;

   assign cnt_inc  = cnt + CNT_W'(1);
   assign cnt_dec  = cnt - CNT_W'(1);
   assign first_up = (period == '0) ? '0 : CNT_W'(1);

   always_comb begin
      cnt_nx = cnt;
      dir_nx = dir_up;
      if (load) begin
         cnt_nx = phase;
         if (mode == CM_UPDN) dir_nx = ph_dir;
         else                 dir_nx = (mode != CM_DOWN);
      end else if (step) begin
         unique case (mode)
            CM_UP: begin
               cnt_nx = (cnt >= period) ? '0 : cnt_inc;
               dir_nx = 1'b1;
            end
            CM_DOWN: begin
               cnt_nx = (cnt == '0) ? period : cnt_dec;
               dir_nx = 1'b0;
            end
            CM_UPDN: begin
               if (dir_up) begin
                  if (cnt >= period) begin
                     dir_nx = 1'b0;
                     cnt_nx = (cnt == '0) ? '0 : cnt_dec;
                  end else begin
                     cnt_nx = cnt_inc;
                  end
               end else begin
                  if (cnt == '0) begin
                     dir_nx = 1'b1;
                     cnt_nx = first_up;
                  end else begin
                     cnt_nx = cnt_dec;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else begin
         cnt    <= cnt_nx;
         dir_up <= dir_nx;
      end
   end

   assert_up_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode == CM_UP && step && !load && cnt >= period |=> cnt == '0);
   assert_down_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode == CM_DOWN && step && !load && cnt == '0 |=> cnt == $past(period));
   assert_updn_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode == CM_UPDN && step && !load && dir_up && cnt == period && period != '0
      |=> cnt == $past(period) - 1'b1 && !dir_up);
   assert_phase_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(phase));
   assert_phase_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load && mode == CM_UPDN |=> dir_up == $past(ph_dir));
   assert_frozen_R14: assert property (@(posedge clk) disable iff (!rst_n)
      mode == CM_HOLD && !load |=> $stable(cnt));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import tbase_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic [1:0]        ctrl_we,
   input  logic [CNT_W-1:0]  period,
   input  logic [CNT_W-1:0]  phase,
   input  logic              sync_in,
   input  logic              halt_req,
   output logic [CNT_W-1:0]  count,
   output logic              count_up
);
   if (CNT_W < 2) begin : g_bad_w
      $error("pwm_timebase: CNT_W must be at least 2");
   end
   if (CD_LSB + PS_CODE_W > CTRL_W || LO_W > 8) begin : g_bad_map
      $error("pwm_timebase: control fields do not fit");
   end

   ctrl_lo_t             lo_q;
   logic [PS_CODE_W-1:0] hs_q, cd_q;
   logic                 tick, step, load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= LO_RESET;
         hs_q <= HS_RESET;
         cd_q <= CD_RESET;
      end else begin
         if (ctrl_we[0]) lo_q <= ctrl_lo_t'(ctrl_word[LO_W-1:0]);
         if (ctrl_we[1]) begin
            hs_q <= ctrl_word[HS_LSB +: PS_CODE_W];
            cd_q <= ctrl_word[CD_LSB +: PS_CODE_W];
         end
      end
   end

   assign load = sync_in && lo_q.ph_en;

   tbase_prescale #(.HS_BITS(PS_CODE_W), .CD_BITS(PS_CODE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctrl_we[1]),
      .hs_code (hs_q),
      .cd_code (cd_q),
      .tick    (tick)
   );

   tbase_halt #(.CNT_W(CNT_W)) u_halt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .halt_req (halt_req),
      .load     (load),
      .emu      (lo_q.emu),
      .mode     (lo_q.mode),
      .cnt      (count),
      .period   (period),
      .step     (step)
   );

   tbase_count #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .load   (load),
      .phase  (phase),
      .ph_dir (lo_q.ph_dir),
      .mode   (lo_q.mode),
      .period (period),
      .cnt    (count),
      .dir_up (count_up)
   );

endmodule

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctrl_word = '0;
   logic [1:0]  ctrl_we = '0;
   logic [15:0] period = 16'hFFFF;
   logic [15:0] phase = '0;
   logic        sync_in = 1'b0;
   logic        halt_req = 1'b0;
   logic [15:0] count;
   logic        count_up;

   int total = 0;
   int bad = 0;
   bit m_up = 1'b1;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pwm_timebase uut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ctrl_we(ctrl_we),
      .period(period), .phase(phase), .sync_in(sync_in), .halt_req(halt_req),
      .count(count), .count_up(count_up)
   );

   function automatic logic [15:0] lo(input int m, input bit pe, input bit pd, input int em);
      return {10'b0, 2'(em), pd, pe, 2'(m)};
   endfunction

   function automatic logic [15:0] hi(input int hs, input int cd);
      return {2'b0, 3'(cd), 3'(hs), 8'b0};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] we, input logic [15:0] w);
      @(negedge clk);
      ctrl_word = w;
      ctrl_we   = we;
      @(negedge clk);
      ctrl_we   = '0;
   endtask

   // expected next value; updates the bench's own direction flag
   function automatic int model_next(input int mode, input int prev, input int p);
      int r;
      r = prev;
      case (mode)
         0: r = (prev >= p) ? 0 : prev + 1;
         1: r = (prev == 0) ? p : prev - 1;
         2: begin
            if (m_up) begin
               if (prev >= p) begin m_up = 1'b0; r = prev - 1; end
               else r = prev + 1;
            end else begin
               if (prev == 0) begin m_up = 1'b1; r = 1; end
               else r = prev - 1;
            end
         end
         default: r = prev;
      endcase
      return r;
   endfunction

   task automatic run_seq(input int mode, input int p, input int n, input string req);
      int prev;
      int exp;
      prev = int'(count);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         exp = model_next(mode, prev, p);
         chk(int'(count) == exp, req, int'(count), exp);
         prev = exp;
      end
   endtask

   task automatic sync_load(input int ph, input string req);
      @(negedge clk);
      phase   = 16'(ph);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      chk(int'(count) == ph, req, int'(count), ph);
   endtask

   task automatic meas(output int d);
      logic [15:0] v;
      int c;
      for (int k = 0; k < 2; k++) begin
         v = count;
         do @(negedge clk); while (count == v);
      end
      v = count;
      c = 0;
      do begin @(negedge clk); c++; end while (count == v);
      d = c;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int d, v, exp;
      repeat (3) @(negedge clk);
      chk(count == 16'd0, "R1 reset value", int'(count), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(count == 16'd0, "R1 frozen after reset", int'(count), 0);

      // R4: only low lane written, prescaler still at its reset divide of 2
      period = 16'hFFFF;
      wr(2'b01, lo(0, 1'b0, 1'b0, 0));
      meas(d);
      chk(d == 2, "R4 default divide", d, 2);

      // R2: first stage sweep
      for (int h = 0; h < 8; h++) begin
         wr(2'b10, hi(h, 0));
         meas(d);
         exp = (h == 0) ? 1 : 2 * h;
         chk(d == exp, "R2 first stage divide", d, exp);
      end
      // R3: second stage sweep
      for (int c = 0; c < 8; c++) begin
         wr(2'b10, hi(0, c));
         meas(d);
         chk(d == (1 << c), "R3 second stage divide", d, 1 << c);
      end
      // R2: products of both stages
      wr(2'b10, hi(3, 2)); meas(d); chk(d == 24, "R2 product 6x4", d, 24);
      wr(2'b10, hi(7, 3)); meas(d); chk(d == 112, "R2 product 14x8", d, 112);
      wr(2'b10, hi(2, 5)); meas(d); chk(d == 128, "R2 product 4x32", d, 128);

      // divide by 1 for the count sweeps
      wr(2'b10, hi(0, 0));
      for (int p = 1; p <= 6; p++) begin
         period = 16'(p);
         wr(2'b01, lo(0, 1'b0, 1'b0, 0));
         run_seq(0, p, 3 * (p + 1) + 2, "R5 up wrap");
      end
      for (int p = 1; p <= 6; p++) begin
         period = 16'(p);
         wr(2'b01, lo(1, 1'b0, 1'b0, 0));
         run_seq(1, p, 3 * (p + 1) + 2, "R6 down reload");
      end
      for (int p = 1; p <= 6; p++) begin
         period = 16'(p);
         wr(2'b01, lo(2, 1'b1, 1'b1, 0));
         sync_load(0, "R8 load before triangle");
         m_up = 1'b1;
         run_seq(2, p, 4 * p + 3, "R7 up-down reversal");
      end

      // R9: direction after a load in up-down mode
      period = 16'd10;
      wr(2'b01, lo(2, 1'b1, 1'b0, 0));
      sync_load(4, "R8 phase load");
      @(negedge clk); chk(count == 16'd3, "R9 dir bit 0 counts down", int'(count), 3);
      wr(2'b01, lo(2, 1'b1, 1'b1, 0));
      sync_load(4, "R8 phase load");
      @(negedge clk); chk(count == 16'd5, "R9 dir bit 1 counts up", int'(count), 5);

      // R8: sync ignored without phase enable
      wr(2'b01, lo(0, 1'b0, 1'b0, 0));
      @(negedge clk);
      v = int'(count);
      phase = 16'd7;
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      exp = (v >= 10) ? 0 : v + 1;
      chk(int'(count) == exp, "R8 sync ignored when disabled", int'(count), exp);

      // R10: direction bit ignored in one-way modes
      wr(2'b01, lo(0, 1'b1, 1'b0, 0));
      sync_load(4, "R8 phase load");
      @(negedge clk); chk(count == 16'd5, "R10 up ignores dir", int'(count), 5);
      wr(2'b01, lo(1, 1'b1, 1'b1, 0));
      sync_load(4, "R8 phase load");
      @(negedge clk); chk(count == 16'd3, "R10 down ignores dir", int'(count), 3);

      // R11: halt on next step
      period = 16'd9;
      wr(2'b01, lo(0, 1'b0, 1'b0, 0));
      @(negedge clk);
      v = int'(count);
      halt_req = 1'b1;
      @(negedge clk);
      exp = (v >= 9) ? 0 : v + 1;
      chk(int'(count) == exp, "R11 one step after halt", int'(count), exp);
      repeat (6) @(negedge clk);
      chk(int'(count) == exp, "R11 held during halt", int'(count), exp);
      halt_req = 1'b0;
      @(negedge clk);
      exp = (exp >= 9) ? 0 : exp + 1;
      chk(int'(count) == exp, "R11 resume after release", int'(count), exp);

      // R11 with a slow tick
      wr(2'b10, hi(2, 0));
      @(negedge clk);
      v = int'(count);
      halt_req = 1'b1;
      repeat (4) @(negedge clk);
      exp = (v >= 9) ? 0 : v + 1;
      chk(int'(count) == exp, "R11 one slow step after halt", int'(count), exp);
      repeat (12) @(negedge clk);
      chk(int'(count) == exp, "R11 held with slow tick", int'(count), exp);
      halt_req = 1'b0;
      wr(2'b10, hi(0, 0));

      // R12: halt at end of cycle
      wr(2'b01, lo(0, 1'b0, 1'b0, 1));
      halt_req = 1'b1;
      repeat (15) @(negedge clk);
      chk(count == 16'd9, "R12 up stops at period", int'(count), 9);
      repeat (5) @(negedge clk);
      chk(count == 16'd9, "R12 up holds", int'(count), 9);
      halt_req = 1'b0;
      @(negedge clk);
      chk(count == 16'd0, "R12 up resumes", int'(count), 0);
      wr(2'b01, lo(1, 1'b0, 1'b0, 1));
      halt_req = 1'b1;
      repeat (15) @(negedge clk);
      chk(count == 16'd0, "R12 down stops at zero", int'(count), 0);
      repeat (5) @(negedge clk);
      chk(count == 16'd0, "R12 down holds", int'(count), 0);
      halt_req = 1'b0;
      @(negedge clk);
      chk(count == 16'd9, "R12 down resumes", int'(count), 9);
      wr(2'b01, lo(2, 1'b0, 1'b0, 1));
      halt_req = 1'b1;
      repeat (25) @(negedge clk);
      chk(count == 16'd0, "R12 up-down stops at zero", int'(count), 0);
      halt_req = 1'b0;
      @(negedge clk);
      chk(count == 16'd1, "R12 up-down resumes", int'(count), 1);

      // R13: halt ignored
      for (int em = 2; em < 4; em++) begin
         wr(2'b01, lo(0, 1'b0, 1'b0, em));
         halt_req = 1'b1;
         run_seq(0, 9, 12, "R13 free run under halt");
         halt_req = 1'b0;
      end

      // R14: frozen mode
      repeat (3) @(negedge clk);
      wr(2'b01, lo(3, 1'b0, 1'b0, 0));
      v = int'(count);
      repeat (10) @(negedge clk);
      chk(int'(count) == v, "R14 frozen holds", int'(count), v);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule